// File: doc/BRIEF.md
# Integer Arithmetic/Logic Execute Unit

This unit is the integer execute stage of a small load-store processor. Each cycle it reads the instruction's primary opcode, its function code and its shift-distance field, plus two register operands and a 16-bit immediate. It decodes those fields itself and registers a 32-bit result, a zero flag and an illegal-operation flag on the next rising clock edge. Branch logic uses the zero flag to make equal and not-equal decisions.

Register-format work uses primary opcode 0x00 and picks the operation from the function code. Immediate-format work picks it from the primary opcode. Both signed and unsigned set-less-than are supported, as are zero-fill and sign-fill right shifts and a load-upper path. Load-upper followed by OR-immediate with the low half builds any 32-bit constant. Arithmetic wraps modulo 2^32 and never traps. Any code outside the supported set gives a zero result and raises the illegal flag.

Top module: `alu_exec`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `res_o`=0, `zero_o`=1 and `illegal_o`=0.
- R2: Outputs change only at a rising edge and reflect the inputs sampled at that edge (one cycle of latency). Between edges they hold their values.
- R3: With opcode 0x00, function 0x20 gives a+b and function 0x22 gives a-b. Opcode 0x08 gives a plus the sign-extended immediate. All three wrap modulo 2^32.
- R4: With opcode 0x00, function 0x24 gives a AND b, 0x25 gives a OR b and 0x27 gives NOT(a OR b). Opcodes 0x0c and 0x0d give AND and OR of a with the zero-extended immediate.
- R5: With opcode 0x00, function 0x00 shifts b left, 0x02 shifts b right with zero fill and 0x03 shifts b right with copies of bit 31. The distance comes from `sh_i`.
- R6: Set-less-than gives 1 when the condition holds and 0 otherwise. The signed compare of a with b uses function 0x2a and the unsigned compare uses 0x2b. The signed compare against the sign-extended immediate uses opcode 0x0a and the unsigned one uses 0x0b.
- R7: Opcode 0x0f places the immediate in bits 31:16 and clears bits 15:0.
- R8: `zero_o` is 1 exactly when the registered `res_o` is zero.
- R9: Any opcode outside {0x00,0x08,0x0a,0x0b,0x0c,0x0d,0x0f}, or opcode 0x00 with a function code outside {0x00,0x02,0x03,0x20,0x22,0x24,0x25,0x27,0x2a,0x2b}, gives `res_o`=0 and `illegal_o`=1. Otherwise `illegal_o` is 0.
- R10: Fields an operation does not use have no effect. `sh_i` and `imm_i` are ignored by non-shift register-format operations, `b_i` is ignored by immediate-format operations, and `a_i` is ignored by shifts and load-upper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Primary opcode |
| fn_i | input | 6 | Function code for register-format operations |
| sh_i | input | 5 | Shift distance |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand, and the shifted value |
| imm_i | input | 16 | Immediate field |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, high when the result is zero |
| illegal_o | output | 1 | Registered flag for an unsupported code |

## Verification
The assertions assume every input is driven to a known value at each rising edge, including during reset. A result is only checked against the inputs of the previous edge when that edge was not itself in reset. The bench always drives defined values: it changes the inputs only on falling edges and holds the opcode at a legal value while reset is high. The illegal-code cases are limited to codes that R9 names as outside the supported set.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0a;
  localparam logic [5:0] OPC_SLTIU = 6'h0b;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_LUI   = 6'h0f;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2a;
  localparam logic [5:0] FN_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SLL, K_SRL, K_SRA, K_AND, K_OR, K_NOR,
    K_SLT, K_SLTU, K_LUI, K_BAD
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      use_imm;   // second operand taken from the immediate
    logic      imm_sext;  // sign-extend (1) or zero-extend (0)
  } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '{kind: K_BAD, use_imm: 1'b0, imm_sext: 1'b0};
    case (op_i)
      OPC_REG: begin
        case (fn_i)
          FN_ADD:  ctl_o.kind = K_ADD;
          FN_SUB:  ctl_o.kind = K_SUB;
          FN_SLL:  ctl_o.kind = K_SLL;
          FN_SRL:  ctl_o.kind = K_SRL;
          FN_SRA:  ctl_o.kind = K_SRA;
          FN_AND:  ctl_o.kind = K_AND;
          FN_OR:   ctl_o.kind = K_OR;
          FN_NOR:  ctl_o.kind = K_NOR;
          FN_SLT:  ctl_o.kind = K_SLT;
          FN_SLTU: ctl_o.kind = K_SLTU;
          default: ctl_o.kind = K_BAD;
        endcase
      end
      OPC_ADDI:  ctl_o = '{kind: K_ADD,  use_imm: 1'b1, imm_sext: 1'b1};
      OPC_SLTI:  ctl_o = '{kind: K_SLT,  use_imm: 1'b1, imm_sext: 1'b1};
      OPC_SLTIU: ctl_o = '{kind: K_SLTU, use_imm: 1'b1, imm_sext: 1'b1};
      OPC_ANDI:  ctl_o = '{kind: K_AND,  use_imm: 1'b1, imm_sext: 1'b0};
      OPC_ORI:   ctl_o = '{kind: K_OR,   use_imm: 1'b1, imm_sext: 1'b0};
      OPC_LUI:   ctl_o = '{kind: K_LUI,  use_imm: 1'b1, imm_sext: 1'b0};
      default:   ctl_o = '{kind: K_BAD,  use_imm: 1'b0, imm_sext: 1'b0};
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] dout_o
);

  logic [DATA_W-1:0] flipped_in;
  logic [DATA_W-1:0] flipped_out;
  logic [DATA_W-1:0] stage [0:SH_W];
  logic              fill;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign flipped_in[i]  = din_i[DATA_W-1-i];
    assign flipped_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign fill     = arith_i & ~left_i & din_i[DATA_W-1];
  assign stage[0] = left_i ? flipped_in : din_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s]
                      ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
                      : stage[s];
  end

  assign dout_o = left_i ? flipped_out : stage[SH_W];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = wide[DATA_W-1:0];

  // Valid when sub_i is set: no carry out means a borrow, so a < b unsigned.
  assign lt_u_o = ~wide[DATA_W];
  assign lt_s_o = (a_i[DATA_W-1] ^ b_i[DATA_W-1]) ? a_i[DATA_W-1]
                                                  : wide[DATA_W-1];

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        op_i,
  input  logic [5:0]        fn_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              illegal_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] shifted;
  logic              lt_s;
  logic              lt_u;
  logic              sub_en;
  logic [DATA_W-1:0] res_d;

  alu_decode u_dec (
    .op_i  (op_i),
    .fn_i  (fn_i),
    .ctl_o (ctl)
  );

  assign imm_ext = ctl.imm_sext ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i}
                                : {{EXT_W{1'b0}}, imm_i};
  assign opnd_b  = ctl.use_imm ? imm_ext : b_i;
  assign sub_en  = (ctl.kind == K_SUB) || (ctl.kind == K_SLT) ||
                   (ctl.kind == K_SLTU);

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a_i    (a_i),
    .b_i    (opnd_b),
    .sub_i  (sub_en),
    .sum_o  (sum),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
    .din_i   (b_i),
    .amt_i   (sh_i),
    .left_i  (ctl.kind == K_SLL),
    .arith_i (ctl.kind == K_SRA),
    .dout_o  (shifted)
  );

  always_comb begin
    case (ctl.kind)
      K_ADD, K_SUB:       res_d = sum;
      K_SLL, K_SRL, K_SRA: res_d = shifted;
      K_AND:              res_d = a_i & opnd_b;
      K_OR:               res_d = a_i | opnd_b;
      K_NOR:              res_d = ~(a_i | opnd_b);
      K_SLT:              res_d = {{(DATA_W-1){1'b0}}, lt_s};
      K_SLTU:             res_d = {{(DATA_W-1){1'b0}}, lt_u};
      K_LUI:              res_d = {imm_i, {EXT_W{1'b0}}};
      default:            res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      zero_o    <= 1'b1;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      zero_o    <= (res_d == '0);
      illegal_o <= (ctl.kind == K_BAD);
    end
  end

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [5:0]        op_i,
  input logic [5:0]        fn_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] res_o,
  input logic              zero_o,
  input logic              illegal_o
);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && zero_o && !illegal_o));

  assert_sub_wraps_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 6'h00 && $past(fn_i) == 6'h22)
    |-> res_o == $past(a_i) - $past(b_i));

  assert_slt_is_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(op_i) == 6'h00 &&
      ($past(fn_i) == 6'h2a || $past(fn_i) == 6'h2b)) ||
      $past(op_i) == 6'h0a || $past(op_i) == 6'h0b))
    |-> res_o[DATA_W-1:1] == '0);

  assert_lui_layout_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 6'h0f)
    |-> (res_o[DATA_W-1:DATA_W-IMM_W] == $past(imm_i) &&
         res_o[DATA_W-IMM_W-1:0] == '0));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  assert_illegal_clears_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> res_o == '0);

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .fn_i      (fn_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .res_o     (res_o),
  .zero_o    (zero_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_alu_exec.sv
`timescale 1ns/1ps
module tb_alu_exec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_i = 6'h00;
  logic [5:0]  fn_i = 6'h20;
  logic [4:0]  sh_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] res_o;
  logic        zero_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  alu_exec dut (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i), .sh_i(sh_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .res_o(res_o), .zero_o(zero_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] res;
    logic        ill;
    logic [7:0]  req;   // requirement number for messages
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'h00, 6'h20, 5'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b0, 8'd3},  // R3 add
    '{6'h00, 6'h20, 5'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b0, 8'd3},  // R3 wrap
    '{6'h00, 6'h22, 5'd0,  32'h00000005, 32'h00000007, 16'h0000, 32'hFFFFFFFE, 1'b0, 8'd3},  // R3 sub
    '{6'h08, 6'h00, 5'd0,  32'h0000000A, 32'h00000000, 16'hFFFF, 32'h00000009, 1'b0, 8'd3},  // R3 addi sext
    '{6'h00, 6'h24, 5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000, 1'b0, 8'd4},  // R4 and
    '{6'h00, 6'h25, 5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hFFF0FFF0, 1'b0, 8'd4},  // R4 or
    '{6'h00, 6'h27, 5'd0,  32'h0F0F0000, 32'h00000F0F, 16'h0000, 32'hF0F0F0F0, 1'b0, 8'd4},  // R4 nor
    '{6'h0c, 6'h00, 5'd0,  32'hFFFFFFFF, 32'h00000000, 16'h8001, 32'h00008001, 1'b0, 8'd4},  // R4 andi zext
    '{6'h0d, 6'h00, 5'd0,  32'h12340000, 32'h00000000, 16'hABCD, 32'h1234ABCD, 1'b0, 8'd4},  // R4 ori
    '{6'h00, 6'h00, 5'd31, 32'h0000FFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b0, 8'd5},  // R5 sll
    '{6'h00, 6'h02, 5'd4,  32'h00000000, 32'h80000000, 16'h0000, 32'h08000000, 1'b0, 8'd5},  // R5 srl
    '{6'h00, 6'h03, 5'd4,  32'h00000000, 32'h80000000, 16'h0000, 32'hF8000000, 1'b0, 8'd5},  // R5 sra neg
    '{6'h00, 6'h03, 5'd31, 32'h00000000, 32'h7FFFFFFF, 16'h0000, 32'h00000000, 1'b0, 8'd5},  // R5 sra pos
    '{6'h00, 6'h2a, 5'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000001, 1'b0, 8'd6},  // R6 slt
    '{6'h00, 6'h2b, 5'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 1'b0, 8'd6},  // R6 sltu
    '{6'h0a, 6'h00, 5'd0,  32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0, 8'd6},  // R6 slti
    '{6'h0b, 6'h00, 5'd0,  32'h00000005, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0, 8'd6},  // R6 sltiu
    '{6'h0a, 6'h00, 5'd0,  32'h00000003, 32'h00000000, 16'h0003, 32'h00000000, 1'b0, 8'd6},  // R6 slti equal
    '{6'h0f, 6'h00, 5'd0,  32'h12345678, 32'h9ABCDEF0, 16'hAAAA, 32'hAAAA0000, 1'b0, 8'd7},  // R7 lui
    '{6'h23, 6'h00, 5'd0,  32'h00000001, 32'h00000001, 16'h0001, 32'h00000000, 1'b1, 8'd9},  // R9 bad opcode
    '{6'h00, 6'h21, 5'd0,  32'h00000001, 32'h00000001, 16'h0000, 32'h00000000, 1'b1, 8'd9},  // R9 bad function
    '{6'h00, 6'h20, 5'd7,  32'h00000003, 32'h00000004, 16'hFFFF, 32'h00000007, 1'b0, 8'd10}, // R10 add ignores sh/imm
    '{6'h08, 6'h00, 5'd0,  32'h00000001, 32'hFFFFFFFF, 16'h0001, 32'h00000002, 1'b0, 8'd10}, // R10 addi ignores b
    '{6'h00, 6'h22, 5'd0,  32'h00000009, 32'h00000009, 16'h0000, 32'h00000000, 1'b0, 8'd8}   // R8 zero result
  };

  task automatic check_eq(input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; fn_i = v.fn; sh_i = v.sh;
    a_i = v.a; b_i = v.b; imm_i = v.imm;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check_eq("R1 res after reset", res_o, 32'h0);
    check_eq("R1 zero after reset", {31'b0, zero_o}, 32'h1);
    check_eq("R1 illegal after reset", {31'b0, illegal_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check_eq($sformatf("R%0d vec%0d res", VECS[i].req, i), res_o, VECS[i].res);
      check_eq($sformatf("R8 vec%0d zero", i), {31'b0, zero_o},
               {31'b0, (VECS[i].res == 32'h0)});
      check_eq($sformatf("R9 vec%0d illegal", i), {31'b0, illegal_o},
               {31'b0, VECS[i].ill});
    end

    // R2: a new input leaves the output alone until the next rising edge
    @(negedge clk);
    drive(VECS[0]);          // result 0x80000000
    @(negedge clk);
    drive(VECS[4]);          // result 0xF000F000
    #1;
    check_eq("R2 hold before edge", res_o, 32'h80000000);
    @(negedge clk);
    check_eq("R2 update after edge", res_o, 32'hF000F000);

    // R1: reset in mid-run overrides a nonzero result and a bad code
    drive(VECS[19]);
    @(negedge clk);
    check_eq("R9 bad code before reset", {31'b0, illegal_o}, 32'h1);
    drive(VECS[0]);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R1 res in reset", res_o, 32'h0);
    check_eq("R1 zero in reset", {31'b0, zero_o}, 32'h1);
    check_eq("R1 illegal in reset", {31'b0, illegal_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 resumes after reset", res_o, 32'h80000000);

    // R10: shift ignores a, load-upper ignores a and b
    drive('{6'h00, 6'h00, 5'd4, 32'hDEADBEEF, 32'h0000000F, 16'h1234, 32'h0, 1'b0, 8'd10});
    @(negedge clk);
    check_eq("R10 sll ignores a and imm", res_o, 32'h000000F0);
    drive('{6'h0f, 6'h00, 5'd9, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0001, 32'h0, 1'b0, 8'd10});
    @(negedge clk);
    check_eq("R10 lui ignores a and b", res_o, 32'h00010000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule